// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Readback Gate

This block is a 16-pin general-purpose I/O port. Software reaches it through a simple strobe interface that reads and writes 16-bit words at fixed byte offsets. The register file holds these registers:

- output levels
- per-pin direction
- per-pin edge polarity
- interrupt mask
- sticky interrupt status
- a pin-enable gate

Pin levels pass through a two-flop synchronizer. After that, a change in the direction chosen for the pin latches a status bit. Any status bit that is not masked raises the single interrupt line.

The pin-enable gate only affects what software reads back from the input register. A cleared gate bit makes that pin read as zero. Edge detection and interrupt latching do not look at the gate. The gate is all ones after reset, so every pin is visible until software narrows it.

Top module: `gpio_pin_port`

## Requirements
- R1: A read of offset 0x00 returns the synchronized pin levels ANDed with the pin-enable register, and writes to 0x00 are ignored.
- R2: The pin-enable register lives at offset 0x18. It is readable and writable and resets to 0xFFFF.
- R3: Reset values are as follows, and the interrupt output is low:
  - output register (0x04): 0x0000
  - direction (0x08): 0xFFFF
  - edge polarity (0x0C): 0xFFFF
  - mask (0x10): 0xFFFF
  - status (0x14): 0x0000
- R4: `pin_out` carries the output register. `pin_oe` is the inverse of the direction register, where a direction bit of 1 means input.
- R5: For a pin whose direction bit is 1, a status bit is set by a synchronized transition in the chosen direction: rising when the polarity bit is 1, falling when it is 0. The bit is visible after the third rising clock edge following the pin change. A transition in the other direction, or on an output pin, sets nothing.
- R6: Writing to offset 0x14 clears the status bits written as 1 and leaves the other bits as they were. A set on the same edge wins over the clear.
- R7: The interrupt output is high exactly when a status bit is 1 and its mask bit is 0. It follows the status register with no added cycle, so it drops on the same edge that clears the status.
- R8: The pin-enable register does not gate edge detection. A pin hidden from readback still latches status.
- R9: A read of an undefined offset returns zero, and a write to an undefined offset changes no register.
- R10: `bus_rdata` is loaded on the rising edge at which `bus_rd` is high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Output enables |
| irq | output | 1 | Interrupt line |

## Verification
Each result is due at a fixed point after its stimulus:

- **Read data** is due one edge after the strobe. The scoreboard queues the expected word when the read is driven, and the monitor compares it 2 ns after that edge.
- **A pin change** reaches the status register on the third rising edge. The bench changes pins at a falling edge and waits three falling edges before it reads.
- **Register writes** are checked at the falling edge after the capturing edge. This covers the interrupt line, which must follow a status clear or a mask write in that same cycle, and the output pins.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int unsigned OFS_IN    = 8'h00;
  localparam int unsigned OFS_OUT   = 8'h04;
  localparam int unsigned OFS_DIR   = 8'h08;
  localparam int unsigned OFS_EDGE  = 8'h0C;
  localparam int unsigned OFS_MASK  = 8'h10;
  localparam int unsigned OFS_STAT  = 8'h14;
  localparam int unsigned OFS_PINEN = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_IN, SEL_OUT, SEL_DIR, SEL_EDGE, SEL_MASK, SEL_STAT, SEL_PINEN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int unsigned ofs);
    case (ofs)
      OFS_IN:    return SEL_IN;
      OFS_OUT:   return SEL_OUT;
      OFS_DIR:   return SEL_DIR;
      OFS_EDGE:  return SEL_EDGE;
      OFS_MASK:  return SEL_MASK;
      OFS_STAT:  return SEL_STAT;
      OFS_PINEN: return SEL_PINEN;
      default:   return SEL_NONE;
    endcase
  endfunction

  function automatic logic [15:0] edge_hits(input logic [15:0] prev,
                                            input logic [15:0] cur,
                                            input logic [15:0] pol,
                                            input logic [15:0] is_in);
    logic [15:0] rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    return ((rise & pol) | (fall & ~pol)) & is_in;
  endfunction

  function automatic logic [15:0] next_status(input logic [15:0] cur,
                                              input logic [15:0] clr,
                                              input logic [15:0] hit);
    return (cur & ~clr) | hit;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced,
  output logic [WIDTH-1:0] synced_prev
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) synced_prev <= '0;
    else        synced_prev <= chain[STAGES-1];
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_events.sv
module gpio_pin_events #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] is_input,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] hit_vec,
  output logic [WIDTH-1:0] status
);
  import gpio_pin_pkg::*;

  assign hit_vec = edge_hits(prev, cur, polarity, is_input);

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= next_status(status, clr_vec, hit_vec);
  end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  sync_in,
  input  logic [WIDTH-1:0]  status,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  pinen_q,
  output logic [WIDTH-1:0]  clr_vec,
  output logic [WIDTH-1:0]  rdata
);
  import gpio_pin_pkg::*;

  reg_sel_e sel;
  logic [WIDTH-1:0] rd_word;

  assign sel     = decode_ofs(int'(addr));
  assign clr_vec = (wr && sel == SEL_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      pol_q   <= '1;
      mask_q  <= '1;
      pinen_q <= '1;
    end else if (wr) begin
      case (sel)
        SEL_OUT:   out_q   <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        SEL_EDGE:  pol_q   <= wdata;
        SEL_MASK:  mask_q  <= wdata;
        SEL_PINEN: pinen_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_IN:    rd_word = sync_in & pinen_q;
      SEL_OUT:   rd_word = out_q;
      SEL_DIR:   rd_word = dir_q;
      SEL_EDGE:  rd_word = pol_q;
      SEL_MASK:  rd_word = mask_q;
      SEL_STAT:  rd_word = status;
      SEL_PINEN: rd_word = pinen_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_word;
  end
endmodule

// File: rtl/gpio_pin_port.sv
module gpio_pin_port #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  logic [WIDTH-1:0] sync_cur, sync_prev;
  logic [WIDTH-1:0] out_q, dir_q, pol_q, mask_q, pinen_q;
  logic [WIDTH-1:0] clr_vec, hit_vec, status;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in),
    .synced(sync_cur), .synced_prev(sync_prev)
  );

  gpio_pin_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .sync_in(sync_cur), .status(status),
    .out_q(out_q), .dir_q(dir_q), .pol_q(pol_q), .mask_q(mask_q),
    .pinen_q(pinen_q), .clr_vec(clr_vec), .rdata(bus_rdata)
  );

  gpio_pin_events #(.WIDTH(WIDTH)) u_events (
    .clk(clk), .rst_n(rst_n), .cur(sync_cur), .prev(sync_prev),
    .polarity(pol_q), .is_input(dir_q), .clr_vec(clr_vec),
    .hit_vec(hit_vec), .status(status)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |(status & ~mask_q);
endmodule

// File: rtl/gpio_pin_port_chk.sv
module gpio_pin_port_chk #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic              irq,
  input logic [WIDTH-1:0]  status,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  pinen_q,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  clr_vec,
  input logic [WIDTH-1:0]  hit_vec
);
  import gpio_pin_pkg::*;

  logic undef_ofs;
  assign undef_ofs = decode_ofs(int'(bus_addr)) == SEL_NONE;

  // R1: input readback never shows a gated pin
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && int'(bus_addr) == OFS_IN) |=> ((bus_rdata & ~$past(pinen_q)) == '0));

  // R5: status bits never drop without a clear
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0));

  // R6: cleared bits are zero unless a set arrived together
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == OFS_STAT) |=>
      ((status & $past(bus_wdata) & ~$past(hit_vec)) == '0));

  // R7: no unmasked pending bit means the line is low
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask_q) == '0) |-> !irq);

  // R9: undefined writes leave the registers unchanged
  p_undef_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && undef_ofs) |=> ($stable(out_q) && $stable(dir_q) &&
                               $stable(mask_q) && $stable(pinen_q)));

  // R9: undefined reads return zero
  p_undef_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && undef_ofs) |=> (bus_rdata == '0));

  // R10: read data holds while no read is strobed
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_pin_port gpio_pin_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .status(status), .mask_q(mask_q), .pinen_q(pinen_q),
  .out_q(out_q), .dir_q(dir_q), .clr_vec(clr_vec), .hit_vec(hit_vec)
);

// File: tb/gpio_pin_port_tb.sv
module gpio_pin_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t sb[$];

  always #4 clk = ~clk;

  gpio_pin_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [15:0] e, input string req);
    rd_item_t it;
    @(negedge clk);
    it.exp = e; it.req = req;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  // monitor: rdata due on the edge that sampled the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && rst_n) begin
        #2;
        if (sb.size() == 0) check("R10 unexpected read", bus_rdata, 16'h0);
        else begin
          rd_item_t it;
          it = sb.pop_front();
          check(it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R3 irq reset", {15'd0, irq}, 16'h0);
    check("R4 pin_out reset", pin_out, 16'h0000);
    check("R4 pin_oe reset", pin_oe, 16'h0000);
    rd_expect(8'h00, 16'h0000, "R1 input reset");
    rd_expect(8'h04, 16'h0000, "R3 out reset");
    rd_expect(8'h08, 16'hFFFF, "R3 dir reset");
    rd_expect(8'h0C, 16'hFFFF, "R3 edge reset");
    rd_expect(8'h10, 16'hFFFF, "R3 mask reset");
    rd_expect(8'h14, 16'h0000, "R3 status reset");
    rd_expect(8'h18, 16'hFFFF, "R2 pinen reset");

    // rising edges on all inputs
    set_pins(16'hA5C3);
    rd_expect(8'h00, 16'hA5C3, "R1 input full");
    rd_expect(8'h14, 16'hA5C3, "R5 rising latch");
    check("R7 all masked irq low", {15'd0, irq}, 16'h0);

    // pin gate
    wr(8'h18, 16'h00FF);
    rd_expect(8'h18, 16'h00FF, "R2 pinen write");
    rd_expect(8'h00, 16'h00C3, "R1 gated input");
    wr(8'h00, 16'h1111);
    rd_expect(8'h00, 16'h00C3, "R1 input read-only");

    // unmask and clear
    wr(8'h10, 16'hFFFE);
    check("R7 unmasked irq high", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0001);
    check("R7 irq drops with clear", {15'd0, irq}, 16'h0000);
    rd_expect(8'h14, 16'hA5C2, "R6 partial clear");
    wr(8'h14, 16'hFFFF);
    rd_expect(8'h14, 16'h0000, "R6 full clear");

    // falling on low byte, rising on hidden bit 9
    wr(8'h0C, 16'hFF00);
    set_pins(16'hA7C1);
    rd_expect(8'h14, 16'h0202, "R5 R8 falling and hidden rising");
    rd_expect(8'h00, 16'h00C1, "R1 gated after change");
    wr(8'h14, 16'hFFFF);
    set_pins(16'hA7C3);
    rd_expect(8'h14, 16'h0000, "R5 wrong direction ignored");

    // outputs and direction
    wr(8'h08, 16'h0FFF);
    wr(8'h04, 16'h1234);
    check("R4 pin_out", pin_out, 16'h1234);
    check("R4 pin_oe", pin_oe, 16'hF000);
    set_pins(16'hB7C3);
    rd_expect(8'h14, 16'h0000, "R5 output pin ignored");

    // undefined offsets
    wr(8'h1C, 16'hFFFF);
    wr(8'h02, 16'h0000);
    rd_expect(8'h1C, 16'h0000, "R9 undefined read zero");
    rd_expect(8'h08, 16'h0FFF, "R9 dir untouched");
    rd_expect(8'h04, 16'h1234, "R9 out untouched");
    rd_expect(8'h10, 16'hFFFE, "R9 mask untouched");

    // hold after read
    rd_expect(8'h04, 16'h1234, "R10 read out");
    repeat (3) @(negedge clk);
    check("R10 rdata holds", bus_rdata, 16'h1234);

    repeat (2) @(negedge clk);
    if (sb.size() != 0) check("R10 pending reads", 16'(sb.size()), 16'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule